// File: doc/BRIEF.md
# Uplink Long Scrambling Chip Generator

This block produces the two binary chip streams of an uplink long scrambling code. It uses two coupled 25-bit linear feedback shift registers. The first register is seeded from a 24-bit code number. The second always starts from all ones. On every enabled clock the block emits a word of `W` chips for each stream, with the earliest chip in bit 0. The default word is 16 chips, and setting `W` to 1 gives a serial, one-chip-per-clock generator.

The first stream is the XOR of the low bits of both registers. The second stream is a fixed XOR of six tapped bits. That XOR yields the same sequence offset by 16,777,232 chips, so no second delayed generator is needed. A frame is 38400 chips long. After the last word of a frame, both registers return to their seeds on their own and the stream restarts. The last word of each frame is flagged.

A load pulse captures a code number and arms the generator. Advance requests made before the first load are ignored. Mapping chips to complex values and applying them to data happen outside this block.

Top module: `long_scram_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, `word_valid` and `frame_last` are 0, and both chip words are 0.
- R2: Until the first `load` is seen, `advance` has no effect: `word_valid` stays 0 and both chip words keep their value.
- R3: A `load` seeds the first register with bits 23..0 equal to `code_num` bits 23..0 and bit 24 equal to 1. It seeds the second register with all 25 bits set to 1. The first word after the load carries chips 0..W-1 of the sequence, with chip 0 in bit 0.
- R4: Each serial step shifts both registers right by one bit. The new bit 24 of the first register is bit 0 XOR bit 3. The new bit 24 of the second register is the XOR of bits 0, 1, 2 and 3. Consecutive words continue the chip sequence without a gap or repeat.
- R5: The first-stream chip is bit 0 of the first register XOR bit 0 of the second register.
- R6: The second-stream chip is the XOR of first-register bits 4, 7 and 18 and second-register bits 4, 6 and 17.
- R7: `word_valid` is 1 in exactly the cycle after an `advance` that was accepted, meaning the generator was armed and `load` was low. When no word is produced, both chip words hold their value.
- R8: `frame_last` is 1 only together with `word_valid`, and only on word number FRAME_CHIPS/W - 1 (word 2399 by default) counted from 0 after the last load or frame restart.
- R9: The word that follows the last word of a frame equals the first word after the load, because both registers are reseeded from the stored code number.
- R10: `load` takes priority over `advance`: a cycle with both high produces no word and restarts the frame. This also holds in the middle of a frame.
- R11: With `W` = 1, the block emits one chip per accepted advance, and the chips form the same stream as the 16-chip configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `code_num`, reseed both registers, start a new frame |
| advance | input | 1 | Request the next word of chips |
| code_num | input | 24 | Scrambling code number |
| c1_word | output | W | First-stream chips, earliest in bit 0 |
| c2_word | output | W | Second-stream chips, earliest in bit 0 |
| word_valid | output | 1 | Chip words updated this cycle |
| frame_last | output | 1 | Current word is the last of the frame |

## Verification
The bench compares every word against a bit-serial model of both registers. It uses the all-zero and all-one code numbers plus random ones, and drives `advance` with random gaps. A feedback tap or a second-stream tap placed wrong shows up as words that diverge within the first frame. Chip order reversed inside a word would put chip 0 in bit W-1.

The frame edge is targeted directly. An off-by-one frame counter would move `frame_last` and start the following word from an unseeded state. A missed reseed would break the match between the first word of the second frame and the first word after load.

A load asserted together with advance, and a reload in the middle of a frame, expose a design that lets advance win. A serial instance confirms that the one-chip configuration yields the identical stream.

// File: rtl/long_scram_gen.sv
module long_scram_gen #(
  parameter int W           = 16,
  parameter int FRAME_CHIPS = 38400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  input  logic [23:0]  code_num,
  output logic [W-1:0] c1_word,
  output logic [W-1:0] c2_word,
  output logic         word_valid,
  output logic         frame_last
);
  localparam int WORDS = FRAME_CHIPS / W;
  localparam int CW    = $clog2(WORDS + 1);

  logic [24:0]   x_q, y_q, x_nx, y_nx;
  logic [23:0]   code_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W-1:0]  c1_nx, c2_nx;
  logic          at_end;

  assign at_end = (cnt_q == CW'(WORDS - 1));

  always_comb begin
    logic [24:0] xs, ys;
    xs = x_q;
    ys = y_q;
    for (int j = 0; j < W; j++) begin
      c1_nx[j] = xs[0] ^ ys[0];
      c2_nx[j] = xs[4] ^ xs[7] ^ xs[18] ^ ys[4] ^ ys[6] ^ ys[17];
      xs = {xs[0] ^ xs[3], xs[24:1]};
      ys = {ys[0] ^ ys[1] ^ ys[2] ^ ys[3], ys[24:1]};
    end
    x_nx = xs;
    y_nx = ys;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q        <= '0;
      y_q        <= '0;
      code_q     <= '0;
      cnt_q      <= '0;
      run_q      <= 1'b0;
      c1_word    <= '0;
      c2_word    <= '0;
      word_valid <= 1'b0;
      frame_last <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      frame_last <= 1'b0;
      if (load) begin
        x_q    <= {1'b1, code_num};
        y_q    <= '1;
        code_q <= code_num;
        cnt_q  <= '0;
        run_q  <= 1'b1;
      end else if (advance && run_q) begin
        c1_word    <= c1_nx;
        c2_word    <= c2_nx;
        word_valid <= 1'b1;
        frame_last <= at_end;
        if (at_end) begin
          x_q   <= {1'b1, code_q};
          y_q   <= '1;
          cnt_q <= '0;
        end else begin
          x_q   <= x_nx;
          y_q   <= y_nx;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/long_scram_chk.sv
module long_scram_chk #(
  parameter int W           = 16,
  parameter int FRAME_CHIPS = 38400
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         advance,
  input logic [W-1:0] c1_word,
  input logic [W-1:0] c2_word,
  input logic         word_valid,
  input logic         frame_last
);
  localparam int WORDS = FRAME_CHIPS / W;
  localparam int CW    = $clog2(WORDS + 1);

  logic [CW-1:0] seen;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= '0;
      armed <= 1'b0;
    end else if (load) begin
      seen  <= '0;
      armed <= 1'b1;
    end else if (word_valid) begin
      seen <= (seen == CW'(WORDS - 1)) ? '0 : seen + 1'b1;
    end
  end

  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> word_valid); // R8
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (frame_last == (seen == CW'(WORDS - 1)))); // R8
  AST_VALID_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(advance && !load)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !word_valid); // R10
  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !word_valid); // R2
  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(c1_word) && $stable(c2_word))); // R7
endmodule

bind long_scram_gen long_scram_chk #(.W(W), .FRAME_CHIPS(FRAME_CHIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
  .c1_word(c1_word), .c2_word(c2_word),
  .word_valid(word_valid), .frame_last(frame_last)
);

// File: tb/sim_long_scram_gen.sv
module sim_long_scram_gen;
  localparam int PERIOD = 10;
  localparam int WORDS  = 2400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        advance = 1'b0;
  logic [23:0] code_num = '0;
  logic [15:0] c1_word, c2_word;
  logic        word_valid, frame_last;
  logic [0:0]  s1_word, s2_word;
  logic        s_valid, s_last;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  long_scram_gen #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .code_num(code_num),
    .c1_word(c1_word), .c2_word(c2_word), .word_valid(word_valid), .frame_last(frame_last));

  long_scram_gen #(.W(1)) u1 (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .code_num(code_num),
    .c1_word(s1_word), .c2_word(s2_word), .word_valid(s_valid), .frame_last(s_last));

  // bit-serial reference state
  logic [24:0] mx, my, nx, ny;
  logic [23:0] mcode;
  int          mcnt, ncnt;
  logic        mrun;
  logic [15:0] e1, e2;
  logic        ev, el, f1, f2, fv;

  function automatic logic chip1(logic [24:0] x, logic [24:0] y);
    return x[0] ^ y[0];
  endfunction
  function automatic logic chip2(logic [24:0] x, logic [24:0] y);
    return x[4] ^ x[7] ^ x[18] ^ y[4] ^ y[6] ^ y[17];
  endfunction
  function automatic logic [24:0] stepx(logic [24:0] x);
    return {x[0] ^ x[3], x[24:1]};
  endfunction
  function automatic logic [24:0] stepy(logic [24:0] y);
    return {y[0] ^ y[1] ^ y[2] ^ y[3], y[24:1]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic ld, input logic adv, input logic [23:0] cn);
    load = ld; advance = adv; code_num = cn;
    ev = 1'b0; el = 1'b0; fv = 1'b0;
    if (ld) begin
      mx = {1'b1, cn}; my = '1; mcode = cn; mcnt = 0; mrun = 1'b1;
      nx = {1'b1, cn}; ny = '1; ncnt = 0;
    end else if (adv && mrun) begin
      for (int j = 0; j < 16; j++) begin
        e1[j] = chip1(mx, my);
        e2[j] = chip2(mx, my);
        mx = stepx(mx); my = stepy(my);
      end
      ev = 1'b1;
      el = (mcnt == WORDS - 1);
      if (el) begin mx = {1'b1, mcode}; my = '1; mcnt = 0; end
      else mcnt++;
      f1 = chip1(nx, ny); f2 = chip2(nx, ny); fv = 1'b1;
      if (ncnt == 38399) begin nx = {1'b1, mcode}; ny = '1; ncnt = 0; end
      else begin nx = stepx(nx); ny = stepy(ny); ncnt++; end
    end
    @(negedge clk);
    check(word_valid == ev, "R7 valid", 32'(word_valid), 32'(ev));
    check(frame_last == el, "R8 frame_last", 32'(frame_last), 32'(el));
    check(c1_word == e1, "R5 R4 c1 word", 32'(c1_word), 32'(e1));
    check(c2_word == e2, "R6 R4 c2 word", 32'(c2_word), 32'(e2));
    check(s_valid == fv, "R11 serial valid", 32'(s_valid), 32'(fv));
    check(s1_word[0] == f1 && s2_word[0] == f2, "R11 serial chips",
          {30'd0, s2_word[0], s1_word[0]}, {30'd0, f2, f1});
  endtask

  task automatic run_frame(input logic [23:0] cn);
    logic [15:0] w1, w2;
    logic        got0, after_last;
    int          words;
    got0 = 1'b0; after_last = 1'b0; words = 0;
    tick(1'b1, 1'b1, cn);
    check(word_valid == 1'b0, "R10 load beats advance", 32'(word_valid), 32'd0);
    while (words < WORDS + 3) begin
      tick(1'b0, ($urandom % 4) != 0, cn);
      if (word_valid) begin
        if (!got0) begin
          w1 = c1_word; w2 = c2_word; got0 = 1'b1;
          // R3: first word starts from the seeded registers
          check(c1_word == e1, "R3 first word", 32'(c1_word), 32'(e1));
        end else if (after_last) begin
          check(c1_word == w1 && c2_word == w2, "R9 frame restart",
                {c2_word, c1_word}, {w2, w1});
        end
        after_last = frame_last;
        if (frame_last)
          check(words == WORDS - 1, "R8 last index", 32'(words), 32'(WORDS - 1));
        words++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    mx = '0; my = '0; nx = '0; ny = '0; mcode = '0; mcnt = 0; ncnt = 0; mrun = 1'b0;
    e1 = '0; e2 = '0; f1 = 1'b0; f2 = 1'b0;
    repeat (3) @(negedge clk);
    check(word_valid == 0 && frame_last == 0 && c1_word == 0 && c2_word == 0,
          "R1 reset", {c2_word, c1_word}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_valid == 0 && c1_word == 0, "R1 after reset", 32'(c1_word), 32'd0);
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, 24'h123456);
    check(word_valid == 0 && c1_word == 0 && c2_word == 0, "R2 advance ignored before load",
          {c2_word, c1_word}, 32'd0);
    run_frame(24'h000000);
    run_frame(24'hFFFFFF);
    run_frame(24'($urandom));
    // R10: reload in mid frame
    tick(1'b1, 1'b0, 24'hA5C3E1);
    for (int k = 0; k < 100; k++) tick(1'b0, 1'b1, 24'hA5C3E1);
    tick(1'b1, 1'b1, 24'h0F0F0F);
    check(word_valid == 0, "R10 mid-frame load", 32'(word_valid), 32'd0);
    tick(1'b0, 1'b1, 24'h0F0F0F);
    run_frame(24'($urandom));
    tick(1'b0, 1'b0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule